// File: doc/BRIEF.md
# CAN Global Control and Buffer-Access Gate

This block holds the global control word of a CAN controller. The word carries three bits. A global operation enable turns the controller on. A forced-shutdown enable is a sticky bit. A read-only access flag shows whether the message-buffer bank and the transmit/receive history bank may be touched. Software never writes bit values directly. Each write names the bits it wants set and the bits it wants cleared, at separate positions in the write word, so one write can change one bit without a read-modify-write.

The access flag is not written by software. It follows events. Setting the enable, or leaving a sleep/stop mode, raises it. Clearing the enable, or entering a sleep/stop mode, drops it. The registered flag drives a gate in front of each attached bank. A write strobe only passes while the flag is high. A read returns the bank's data one cycle later, or zero while the flag is low. Register reads also answer one cycle after the request.

Top module: `can_gcr_top`

## Requirements
- R1: A synchronous active-high reset brings the enable, the shutdown enable and the access flag to 0. After reset, a register read returns 0x0000 and all bank outputs are 0.
- R2: A register read (select high, write-enable low) places a word on `cfg_rdata` at the next clock edge. The word has the access flag at bit 15, the shutdown enable at bit 1 and the operation enable at bit 0, with 0 in every other bit. In a cycle without a read request, `cfg_rdata` returns to 0x0000 at the next edge.
- R3: A register write with bit 8 set sets the operation enable. A write with bit 0 set clears it. A write with both bits set leaves the enable unchanged.
- R4: A write with bit 9 set sets the shutdown enable. No write clears it; only reset does.
- R5: All write bits other than 0, 8 and 9 are ignored. This includes bit 15: writing 1 there while the access flag is 0 leaves the flag at 0.
- R6: The access flag becomes 1 at the edge after a sleep/stop release pulse, or after a write that sets the operation enable.
- R7: The access flag becomes 0 at the edge after a sleep/stop entry pulse, or after a write that clears the operation enable. A clear event wins over a set event in the same cycle.
- R8: Each bank write strobe passes to its gated output in the same cycle while the registered access flag is 1. It is held at 0 while the flag is 0.
- R9: A bank read request returns that bank's raw data on its gated read output at the next edge when the access flag is 1. It returns 0 when the flag is 0 or when no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sel | input | 1 | Register bus select |
| cfg_we | input | 1 | Register bus write enable |
| cfg_wdata | input | 16 | Register write word (set/clear positions) |
| cfg_rdata | output | 16 | Registered register read word |
| pm_enter | input | 1 | Sleep/stop mode entry pulse |
| pm_release | input | 1 | Sleep/stop mode release pulse |
| buf_access_en | output | 1 | Registered access flag for the banks |
| bank_wr_req | input | NBANK | Write strobes toward the banks |
| bank_wr_ok | output | NBANK | Gated write strobes |
| bank_rd_req | input | NBANK | Read requests toward the banks |
| bank_rd_raw | input | NBANK*BANK_DW | Raw read data from the banks |
| bank_rd_data | output | NBANK*BANK_DW | Gated, registered read data |

## Verification
If the access flag is wrong inside the block, it shows up in three ways. Bank write strobes are dropped or wrongly passed in the same cycle. Bank read returns turn to zero or leak data one cycle later. Bit 15 of the next register read is wrong. A wrong enable or shutdown bit is only visible through a register read, so every stimulus step is followed by a read, and the bad bit appears one edge after that request. Simultaneous entry/set and release/clear pulses are driven on purpose, because a wrong priority choice leaves no other trace.

// File: rtl/can_gcr_pkg.sv
package can_gcr_pkg;
  localparam int REG_W       = 16;
  // read view positions
  localparam int RD_GOM      = 0;
  localparam int RD_SHUT     = 1;
  localparam int RD_ACC      = 15;
  // write view positions
  localparam int WR_EN_CLR   = 0;
  localparam int WR_EN_SET   = 8;
  localparam int WR_SHUT_SET = 9;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic shut_set;
  } wr_ev_t;

  typedef struct packed {
    logic acc;
    logic shut;
    logic en;
  } gcr_state_t;
endpackage

// File: rtl/can_gcr_decode.sv
module can_gcr_decode
  import can_gcr_pkg::*;
(
  input  logic             sel,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output wr_ev_t           ev
);
  logic wr;
  logic set_b;
  logic clr_b;

  always_comb begin
    wr          = sel & we;
    set_b       = wdata[WR_EN_SET];
    clr_b       = wdata[WR_EN_CLR];
    // a write naming both positions is treated as no request for the enable
    ev.en_set   = wr & set_b & ~clr_b;
    ev.en_clr   = wr & clr_b & ~set_b;
    ev.shut_set = wr & wdata[WR_SHUT_SET];
  end
endmodule

// File: rtl/can_gcr_state.sv
module can_gcr_state
  import can_gcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wr_ev_t     ev,
  input  logic       pm_enter,
  input  logic       pm_release,
  output gcr_state_t st
);
  logic drop_acc;
  logic raise_acc;

  always_comb begin
    drop_acc  = pm_enter | ev.en_clr;
    raise_acc = pm_release | ev.en_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      if (ev.en_set)      st.en <= 1'b1;
      else if (ev.en_clr) st.en <= 1'b0;

      if (ev.shut_set)    st.shut <= 1'b1;

      if (drop_acc)       st.acc <= 1'b0;
      else if (raise_acc) st.acc <= 1'b1;
    end
  end
endmodule

// File: rtl/can_gcr_rdport.sv
module can_gcr_rdport
  import can_gcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  gcr_state_t       st,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] view;

  always_comb begin
    view         = '0;
    view[RD_GOM] = st.en;
    view[RD_SHUT]= st.shut;
    view[RD_ACC] = st.acc;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= view;
    else         rdata <= '0;
  end
endmodule

// File: rtl/can_gcr_gate.sv
module can_gcr_gate #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          open,
  input  logic          wr_req,
  output logic          wr_ok,
  input  logic          rd_req,
  input  logic [DW-1:0] rd_raw,
  output logic [DW-1:0] rd_data
);
  assign wr_ok = wr_req & open;

  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (rd_req && open)  rd_data <= rd_raw;
    else                      rd_data <= '0;
  end
endmodule

// File: rtl/can_gcr_top.sv
module can_gcr_top
  import can_gcr_pkg::*;
#(
  parameter int NBANK   = 2,
  parameter int BANK_DW = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_sel,
  input  logic                     cfg_we,
  input  logic [15:0]              cfg_wdata,
  output logic [15:0]              cfg_rdata,
  input  logic                     pm_enter,
  input  logic                     pm_release,
  output logic                     buf_access_en,
  input  logic [NBANK-1:0]         bank_wr_req,
  output logic [NBANK-1:0]         bank_wr_ok,
  input  logic [NBANK-1:0]         bank_rd_req,
  input  logic [NBANK*BANK_DW-1:0] bank_rd_raw,
  output logic [NBANK*BANK_DW-1:0] bank_rd_data
);
  localparam int BUS_W = NBANK * BANK_DW;

  wr_ev_t     ev;
  gcr_state_t st;
  logic       cfg_rd;

  assign cfg_rd        = cfg_sel & ~cfg_we;
  assign buf_access_en = st.acc;

  can_gcr_decode u_dec (
    .sel   (cfg_sel),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .ev    (ev)
  );

  can_gcr_state u_st (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .pm_enter   (pm_enter),
    .pm_release (pm_release),
    .st         (st)
  );

  can_gcr_rdport u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (cfg_rd),
    .st    (st),
    .rdata (cfg_rdata)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    can_gcr_gate #(.DW(BANK_DW)) u_gate (
      .clk     (clk),
      .rst     (rst),
      .open    (st.acc),
      .wr_req  (bank_wr_req[b]),
      .wr_ok   (bank_wr_ok[b]),
      .rd_req  (bank_rd_req[b]),
      .rd_raw  (bank_rd_raw[b*BANK_DW +: BANK_DW]),
      .rd_data (bank_rd_data[b*BANK_DW +: BANK_DW])
    );
  end

  if (BUS_W < NBANK) begin : g_bad_cfg
    initial $error("bank width must be at least 1");
  end
endmodule

// File: rtl/can_gcr_chk.sv
module can_gcr_chk #(
  parameter int NBANK   = 2,
  parameter int BANK_DW = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_sel,
  input logic                     cfg_we,
  input logic [15:0]              cfg_wdata,
  input logic [15:0]              cfg_rdata,
  input logic                     pm_enter,
  input logic                     pm_release,
  input logic                     buf_access_en,
  input logic [NBANK-1:0]         bank_wr_ok,
  input logic [NBANK-1:0]         bank_rd_req,
  input logic [NBANK*BANK_DW-1:0] bank_rd_data,
  input logic [2:0]               st_bits
);
  logic wr, both_en, clr_only, set_only, idle_bits;
  assign wr        = cfg_sel & cfg_we;
  assign both_en   = wr & cfg_wdata[0] & cfg_wdata[8];
  assign clr_only  = wr & cfg_wdata[0] & ~cfg_wdata[8];
  assign set_only  = wr & cfg_wdata[8] & ~cfg_wdata[0];
  assign idle_bits = ~cfg_wdata[0] & ~cfg_wdata[8] & ~cfg_wdata[9];

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (cfg_rdata == 16'h0000 && !buf_access_en && bank_rd_data == '0));

  // R2
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_sel && !cfg_we) |=> cfg_rdata == 16'h0000);

  // R2
  rd_spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel && !cfg_we) |=> cfg_rdata[14:2] == '0);

  // R3
  en_both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    both_en |=> $stable(st_bits[0]));

  // R4
  shut_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    st_bits[1] |=> st_bits[1]);

  // R5
  ignored_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && idle_bits && !pm_enter && !pm_release) |=> $stable(st_bits));

  // R6
  acc_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((pm_release || set_only) && !pm_enter && !clr_only) |=> buf_access_en);

  // R7
  acc_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_enter || clr_only) |=> !buf_access_en);

  // R8
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !buf_access_en |-> bank_wr_ok == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_rd
    // R9
    rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!bank_rd_req[b] || !buf_access_en) |=> bank_rd_data[b*BANK_DW +: BANK_DW] == '0);
  end
endmodule

bind can_gcr_top can_gcr_chk #(.NBANK(NBANK), .BANK_DW(BANK_DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_sel       (cfg_sel),
  .cfg_we        (cfg_we),
  .cfg_wdata     (cfg_wdata),
  .cfg_rdata     (cfg_rdata),
  .pm_enter      (pm_enter),
  .pm_release    (pm_release),
  .buf_access_en (buf_access_en),
  .bank_wr_ok    (bank_wr_ok),
  .bank_rd_req   (bank_rd_req),
  .bank_rd_data  (bank_rd_data),
  .st_bits       (st)
);

// File: tb/test_can_gcr_top.sv
module test_can_gcr_top;
  localparam int CLK_P   = 10;
  localparam int NBANK   = 2;
  localparam int BANK_DW = 32;
  localparam int NV      = 15;

  typedef struct packed {
    logic [3:0]  req;   // requirement number
    logic        ent;
    logic        rel;
    logic        wr;
    logic [15:0] wd;
    logic [15:0] exp_rd;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd3, 1'b0, 1'b0, 1'b1, 16'h0100, 16'h8001},
    '{4'd4, 1'b0, 1'b0, 1'b1, 16'h0200, 16'h8003},
    '{4'd7, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0003},
    '{4'd6, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h8003},
    '{4'd7, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0003},
    '{4'd5, 1'b0, 1'b0, 1'b1, 16'h8000, 16'h0003},
    '{4'd5, 1'b0, 1'b0, 1'b1, 16'h7CFE, 16'h0003},
    '{4'd3, 1'b0, 1'b0, 1'b1, 16'h0101, 16'h0003},
    '{4'd7, 1'b0, 1'b0, 1'b1, 16'h0001, 16'h0002},
    '{4'd3, 1'b0, 1'b0, 1'b1, 16'h0101, 16'h0002},
    '{4'd6, 1'b0, 1'b0, 1'b1, 16'h0100, 16'h8003},
    '{4'd7, 1'b0, 1'b0, 1'b1, 16'h0001, 16'h0002},
    '{4'd6, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h8002},
    '{4'd7, 1'b1, 1'b0, 1'b1, 16'h0100, 16'h0003},
    '{4'd7, 1'b0, 1'b1, 1'b1, 16'h0001, 16'h0002}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_sel = 1'b0, cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic pm_enter = 1'b0, pm_release = 1'b0;
  logic buf_access_en;
  logic [NBANK-1:0] bank_wr_req = '0, bank_wr_ok, bank_rd_req = '0;
  logic [NBANK*BANK_DW-1:0] bank_rd_raw = '0, bank_rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  can_gcr_top #(.NBANK(NBANK), .BANK_DW(BANK_DW)) i_can_gcr_top (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pm_enter(pm_enter),
    .pm_release(pm_release), .buf_access_en(buf_access_en),
    .bank_wr_req(bank_wr_req), .bank_wr_ok(bank_wr_ok),
    .bank_rd_req(bank_rd_req), .bank_rd_raw(bank_rd_raw),
    .bank_rd_data(bank_rd_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic ent, input logic rel, input logic wr, input logic [15:0] wd);
    @(negedge clk);
    pm_enter = ent; pm_release = rel;
    cfg_sel = wr; cfg_we = wr; cfg_wdata = wd;
    @(negedge clk);
    pm_enter = 0; pm_release = 0; cfg_sel = 0; cfg_we = 0; cfg_wdata = '0;
  endtask

  task automatic rd_reg(output logic [15:0] v);
    @(negedge clk);
    cfg_sel = 1; cfg_we = 0;
    @(negedge clk);
    cfg_sel = 0;
    v = cfg_rdata;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 rdata", cfg_rdata, 0);
    check("R1 access", buf_access_en, 0);
    check("R1 bank rd", bank_rd_data, 0);
    rd_reg(v);
    check("R1 read", v, 16'h0000);

    // R8 R9 gate closed after reset
    @(negedge clk);
    bank_wr_req = 2'b11; bank_rd_req = 2'b11;
    bank_rd_raw = 64'hDEADBEEF_12345678;
    #1 check("R8 closed", bank_wr_ok, 0);
    @(negedge clk);
    check("R9 closed", bank_rd_data, 0);
    bank_wr_req = '0; bank_rd_req = '0;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      op(VEC[i].ent, VEC[i].rel, VEC[i].wr, VEC[i].wd);
      rd_reg(v);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].exp_rd);
    end

    // R2 no read request: data returns to zero
    @(negedge clk);
    check("R2 idle", cfg_rdata, 0);

    // R8 R9 gate open
    op(0, 0, 1, 16'h0100);
    check("R6 flag", buf_access_en, 1);
    @(negedge clk);
    bank_wr_req = 2'b10; bank_rd_req = 2'b01;
    #1 check("R8 open", bank_wr_ok, 2'b10);
    @(negedge clk);
    check("R9 open", bank_rd_data, 64'h00000000_12345678);
    bank_wr_req = '0; bank_rd_req = '0;
    @(negedge clk);
    check("R9 no req", bank_rd_data, 0);

    // R4 reset is the only clear for the shutdown enable
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd_reg(v);
    check("R4 R1 reset clears", v, 16'h0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule